// File: doc/BRIEF.md
# Static LCD Driver for Three and a Half Digits

This block drives a non-multiplexed liquid crystal panel that shows three full seven-segment digits, a leading half digit that can only show "1", and a minus sign. A converter hands it a reading as BCD digits plus a negative flag, an overrange flag and a flag for the leading 1. The reading is captured on a one-cycle load strobe and held, so the panel stays steady between conversions.

Every segment line and the shared backplane line carry the same square wave, and the average voltage across each segment is zero. The backplane is the input clock divided by a parameter (800 by default). A segment that should be dark follows the backplane. A segment that should be lit is its inverse. A lamp-test input overrides the decoding and drives every segment line to a constant high level.

Top module: `lcd_static_drv`

## Requirements
- R1: `bp_out` is low out of reset and toggles once every CLK_DIV/2 clock edges, giving a 50% duty square wave at the clock rate divided by CLK_DIV. The first toggle comes on the CLK_DIV/2-th rising edge after reset is released.
- R2: On a rising edge with `load` high, the display inputs are captured and the outputs show them from that edge on. Changes to the display inputs without `load` have no effect on any output.
- R3: Outside lamp test, a dark segment line equals `bp_out` and a lit segment line equals the inverse of `bp_out`. This holds for `seg_out`, `half_out` and `sign_out`.
- R4: Digit d (d=0 is units) takes BCD bits [4d+3:4d] and drives `seg_out[7d+6:7d]`, with bit 0 to bit 6 being segments a to g. The lit sets in hex are 0:3F, 1:06, 2:5B, 3:4F, 4:66, 5:6D, 6:7D, 7:07, 8:7F, 9:6F.
- R5: A digit holding a BCD code from 10 to 15 is blank, with all seven segments dark.
- R6: `half_out`, the single line for the two segments of the leading 1, is lit when the captured leading-one flag is set.
- R7: `sign_out` is lit when the captured negative flag is set and dark when it is clear.
- R8: When the captured overrange flag is set, all three full digits are blank, the leading 1 is lit whatever its flag says, and the sign still follows the negative flag.
- R9: While `lamp_test` is high, every segment, half-digit and sign line is held at a constant 1 and `bp_out` keeps running. When it drops, the outputs return to the captured reading at once.
- R10: Synchronous reset clears the captured reading to zero, so the panel shows "000" with the half digit and sign dark.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous reset, active high |
| load | input | 1 | Capture strobe for a new reading |
| digits_bcd | input | 4*DIGITS | BCD digits, units in the low nibble |
| one_in | input | 1 | Leading half digit shows 1 |
| neg_in | input | 1 | Reading is negative |
| ovr_in | input | 1 | Reading is over range |
| lamp_test | input | 1 | Force all segment lines high |
| seg_out | output | 7*DIGITS | Segment lines a..g per full digit |
| half_out | output | 1 | Leading-1 segment pair line |
| sign_out | output | 1 | Minus sign line |
| bp_out | output | 1 | Shared backplane square wave |

## Verification
Two functions can meet on one rising edge: the load of a new reading and the toggle of the backplane. The bench waits until the next edge is a toggle edge and raises `load` there. It then expects both the new segment pattern and the flipped phase on the first sample after that edge. It also holds lamp test high while overrange is captured, and expects the forced level to win over blanking and the blanked pattern to come back when lamp test is released.

// File: rtl/lcd_drv_pkg.sv
package lcd_drv_pkg;

   localparam int SEG_W = 7;

   typedef logic [3:0]       bcd_t;
   typedef logic [SEG_W-1:0] seg7_t;

   // bit 0 = segment a ... bit 6 = segment g; invalid codes blank
   function automatic seg7_t bcd_to_seg(input bcd_t v);
      seg7_t s;
      case (v)
         4'd0:    s = 7'h3F;
         4'd1:    s = 7'h06;
         4'd2:    s = 7'h5B;
         4'd3:    s = 7'h4F;
         4'd4:    s = 7'h66;
         4'd5:    s = 7'h6D;
         4'd6:    s = 7'h7D;
         4'd7:    s = 7'h07;
         4'd8:    s = 7'h7F;
         4'd9:    s = 7'h6F;
         default: s = 7'h00;
      endcase
      return s;
   endfunction

endpackage

// File: rtl/lcd_bp_divider.sv
module lcd_bp_divider #(
   parameter int CLK_DIV = 800
) (
   input  logic clk,
   input  logic rst,
   output logic bp
);
   localparam int HALF = CLK_DIV / 2;
   localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;
   localparam logic [CW-1:0] LAST = CW'(HALF - 1);

   generate
      if (CLK_DIV < 2 || (CLK_DIV % 2) != 0) begin : g_bad_div
         $error("CLK_DIV must be even and at least 2");
      end
   endgenerate

   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt <= '0;
         bp  <= 1'b0;
      end else if (cnt == LAST) begin
         cnt <= '0;
         bp  <= ~bp;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end

   assert_cnt_range_R1: assert property (@(posedge clk) disable iff (rst)
      cnt <= LAST);

   assert_toggle_point_R1: assert property (@(posedge clk) disable iff (rst)
      (bp != $past(bp)) |-> ($past(cnt) == LAST));

endmodule

// File: rtl/lcd_reading_latch.sv
module lcd_reading_latch #(
   parameter int DIGITS = 3
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  load,
   input  logic [4*DIGITS-1:0]   digits_in,
   input  logic                  one_in,
   input  logic                  neg_in,
   input  logic                  ovr_in,
   output logic [4*DIGITS-1:0]   q_digits,
   output logic                  q_one,
   output logic                  q_neg,
   output logic                  q_ovr
);
   generate
      if (DIGITS < 1) begin : g_bad_digits
         $error("DIGITS must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         q_digits <= '0;
         q_one    <= 1'b0;
         q_neg    <= 1'b0;
         q_ovr    <= 1'b0;
      end else if (load) begin
         q_digits <= digits_in;
         q_one    <= one_in;
         q_neg    <= neg_in;
         q_ovr    <= ovr_in;
      end
   end

   assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
      !load |=> ($stable(q_digits) && $stable(q_one) && $stable(q_neg) && $stable(q_ovr)));

   assert_capture_R2: assert property (@(posedge clk) disable iff (rst)
      load |=> (q_digits == $past(digits_in) && q_ovr == $past(ovr_in)));

endmodule

// File: rtl/lcd_seg_decoder.sv
module lcd_seg_decoder
   import lcd_drv_pkg::*;
#(
   parameter int DIGITS = 3
) (
   input  logic [4*DIGITS-1:0]     q_digits,
   input  logic                    q_one,
   input  logic                    q_neg,
   input  logic                    q_ovr,
   output logic [SEG_W*DIGITS-1:0] dig_on,
   output logic                    one_on,
   output logic                    sign_on
);
   genvar d;
   generate
      for (d = 0; d < DIGITS; d++) begin : g_digit
         assign dig_on[SEG_W*d +: SEG_W] =
            q_ovr ? '0 : bcd_to_seg(q_digits[4*d +: 4]);
      end
   endgenerate

   assign one_on  = q_one | q_ovr;
   assign sign_on = q_neg;

endmodule

// File: rtl/lcd_static_drv.sv
module lcd_static_drv
   import lcd_drv_pkg::*;
#(
   parameter int CLK_DIV = 800,
   parameter int DIGITS  = 3
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    load,
   input  logic [4*DIGITS-1:0]     digits_bcd,
   input  logic                    one_in,
   input  logic                    neg_in,
   input  logic                    ovr_in,
   input  logic                    lamp_test,
   output logic [SEG_W*DIGITS-1:0] seg_out,
   output logic                    half_out,
   output logic                    sign_out,
   output logic                    bp_out
);
   localparam int SEG_BITS = SEG_W * DIGITS;

   logic [4*DIGITS-1:0] q_digits;
   logic                q_one, q_neg, q_ovr;
   logic [SEG_BITS-1:0] dig_on;
   logic                one_on, sign_on;

   lcd_bp_divider #(.CLK_DIV(CLK_DIV)) u_div (
      .clk (clk),
      .rst (rst),
      .bp  (bp_out)
   );

   lcd_reading_latch #(.DIGITS(DIGITS)) u_latch (
      .clk       (clk),
      .rst       (rst),
      .load      (load),
      .digits_in (digits_bcd),
      .one_in    (one_in),
      .neg_in    (neg_in),
      .ovr_in    (ovr_in),
      .q_digits  (q_digits),
      .q_one     (q_one),
      .q_neg     (q_neg),
      .q_ovr     (q_ovr)
   );

   lcd_seg_decoder #(.DIGITS(DIGITS)) u_dec (
      .q_digits (q_digits),
      .q_one    (q_one),
      .q_neg    (q_neg),
      .q_ovr    (q_ovr),
      .dig_on   (dig_on),
      .one_on   (one_on),
      .sign_on  (sign_on)
   );

   // phase stage: lit lines run in antiphase, lamp test holds them high
   genvar i;
   generate
      for (i = 0; i < SEG_BITS; i++) begin : g_phase
         assign seg_out[i] = lamp_test | (bp_out ^ dig_on[i]);
      end
   endgenerate

   assign half_out = lamp_test | (bp_out ^ one_on);
   assign sign_out = lamp_test | (bp_out ^ sign_on);

   assert_lamp_all_high_R9: assert property (@(posedge clk) disable iff (rst)
      lamp_test |-> ((&seg_out) && half_out && sign_out));

   assert_ovr_blank_R8: assert property (@(posedge clk) disable iff (rst)
      (q_ovr && !lamp_test) |-> (seg_out == {SEG_BITS{bp_out}} && half_out != bp_out));

   assert_half_dark_phase_R3: assert property (@(posedge clk) disable iff (rst)
      (!lamp_test && !q_one && !q_ovr) |-> (half_out == bp_out));

   assert_sign_follow_R7: assert property (@(posedge clk) disable iff (rst)
      !lamp_test |-> ((sign_out != bp_out) == q_neg));

endmodule

// File: tb/lcd_static_drv_bench.sv
module lcd_static_drv_bench;
   localparam int DIV  = 800;
   localparam int HALF = DIV / 2;
   localparam int ND   = 3;
   localparam int SB   = 7 * ND;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic load = 1'b0;
   logic [4*ND-1:0] digits_bcd = '0;
   logic one_in = 1'b0, neg_in = 1'b0, ovr_in = 1'b0, lamp_test = 1'b0;
   logic [SB-1:0] seg_out;
   logic half_out, sign_out, bp_out;

   int checks = 0;
   int fails  = 0;
   int edges  = 0;

   // model of captured reading
   logic [4*ND-1:0] m_dig = '0;
   logic m_one = 1'b0, m_neg = 1'b0, m_ovr = 1'b0;

   always #4 clk = ~clk;

   always @(posedge clk) begin
      if (rst) edges <= 0;
      else     edges <= edges + 1;
   end

   lcd_static_drv #(.CLK_DIV(DIV), .DIGITS(ND)) u_lcd_static_drv (
      .clk (clk), .rst (rst), .load (load), .digits_bcd (digits_bcd),
      .one_in (one_in), .neg_in (neg_in), .ovr_in (ovr_in),
      .lamp_test (lamp_test), .seg_out (seg_out), .half_out (half_out),
      .sign_out (sign_out), .bp_out (bp_out)
   );

   function automatic logic [6:0] ref_seg(input logic [3:0] v);
      case (v)
         4'd0: return 7'h3F;  4'd1: return 7'h06;  4'd2: return 7'h5B;
         4'd3: return 7'h4F;  4'd4: return 7'h66;  4'd5: return 7'h6D;
         4'd6: return 7'h7D;  4'd7: return 7'h07;  4'd8: return 7'h7F;
         4'd9: return 7'h6F;  default: return 7'h00;
      endcase
   endfunction

   function automatic logic [SB-1:0] ref_on();
      logic [SB-1:0] r;
      for (int d = 0; d < ND; d++)
         r[7*d +: 7] = m_ovr ? 7'h00 : ref_seg(m_dig[4*d +: 4]);
      return r;
   endfunction

   task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h (edge %0d)", tag, act, exp, edges);
      end
   endtask

   // sample away from the rising edge
   task automatic check_all(input string tag);
      logic          ebp;
      logic [SB-1:0] eseg;
      logic          ehalf, esign;
      @(negedge clk);
      ebp = ((edges / HALF) % 2) == 1;
      if (lamp_test) begin
         eseg = '1; ehalf = 1'b1; esign = 1'b1;
      end else begin
         eseg  = ref_on() ^ {SB{ebp}};
         ehalf = (m_one | m_ovr) ^ ebp;
         esign = m_neg ^ ebp;
      end
      cmp({tag, " R1 bp_out"}, 32'(bp_out), 32'(ebp));
      cmp({tag, " R3/R4 seg_out"}, 32'(seg_out), 32'(eseg));
      cmp({tag, " R6 half_out"}, 32'(half_out), 32'(ehalf));
      cmp({tag, " R7 sign_out"}, 32'(sign_out), 32'(esign));
   endtask

   task automatic set_in(input logic [4*ND-1:0] dg, input logic o, input logic n, input logic v);
      digits_bcd = dg; one_in = o; neg_in = n; ovr_in = v;
   endtask

   // drive just after an edge, capture at the next edge
   task automatic do_load(input logic [4*ND-1:0] dg, input logic o, input logic n, input logic v);
      @(posedge clk); #1;
      set_in(dg, o, n, v);
      load = 1'b1;
      @(posedge clk); #1;
      load = 1'b0;
      m_dig = dg; m_one = o; m_neg = n; m_ovr = v;
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) @(posedge clk);
   endtask

   initial begin
      #(64'd8 * 64'd200000);
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      void'($urandom(32'd2024));
      idle(5);
      @(posedge clk); #1;
      rst = 1'b0;
      check_all("R10 reset");

      // R2: inputs move without load
      @(posedge clk); #1;
      set_in(12'h987, 1'b1, 1'b1, 1'b1);
      idle(3);
      check_all("R2 no-load");

      // R4 all codes, R5 invalid codes
      for (int v = 0; v < 16; v += 3) begin
         do_load({4'(v), 4'(v + 1), 4'(v + 2)}, 1'b0, 1'b0, 1'b0);
         check_all(v > 7 ? "R5 code" : "R4 code");
      end
      do_load(12'hFAB, 1'b0, 1'b0, 1'b0);
      check_all("R5 blank");

      // R6, R7, R8
      do_load(12'h123, 1'b1, 1'b0, 1'b0);
      check_all("R6 one");
      do_load(12'h456, 1'b0, 1'b1, 1'b0);
      check_all("R7 neg");
      do_load(12'h888, 1'b0, 1'b1, 1'b1);
      check_all("R8 ovr neg");
      do_load(12'h888, 1'b0, 1'b0, 1'b1);
      check_all("R8 ovr pos");

      // R9 lamp over overrange, then release
      @(posedge clk); #1;
      lamp_test = 1'b1;
      check_all("R9 lamp on");
      idle(HALF);
      check_all("R9 lamp hold");
      @(posedge clk); #1;
      lamp_test = 1'b0;
      check_all("R9 lamp off");

      // load coinciding with a backplane toggle edge
      for (int t = 0; t < 2; t++) begin
         @(posedge clk); #1;
         while ((edges % HALF) != HALF - 1) begin
            @(posedge clk); #1;
         end
         set_in(t == 0 ? 12'h250 : 12'h917, 1'b1, t == 0, 1'b0);
         load = 1'b1;
         @(posedge clk); #1;
         load = 1'b0;
         m_dig = digits_bcd; m_one = one_in; m_neg = neg_in; m_ovr = ovr_in;
         check_all("R2 load at toggle");
      end

      // constrained random readings
      for (int it = 0; it < 60; it++) begin
         logic [4*ND-1:0] dg;
         for (int d = 0; d < ND; d++)
            dg[4*d +: 4] = (($urandom % 8) == 0) ? 4'($urandom % 16) : 4'($urandom % 10);
         do_load(dg, 1'($urandom % 2), 1'($urandom % 2), ($urandom % 5) == 0);
         check_all("R3 random");
         @(posedge clk); #1;
         set_in(12'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
         lamp_test = ($urandom % 6) == 0;
         idle(1 + ($urandom % 500));
         check_all(lamp_test ? "R9 random" : "R2 random hold");
         @(posedge clk); #1;
         lamp_test = 1'b0;
      end

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule